// File: doc/BRIEF.md
# Eight-Channel DAC Serial Control Logic

This block is the digital front end of an eight-channel voltage-output converter. A host writes 32-bit command words over a three-wire serial link made of a clock, an active-low frame strobe and a data line. Each channel has two registers in series: a staging register that writes land in, and an output register that alone drives the converter code. Moving staged values to the outputs happens through software commands, through a hardware load strobe, or both. A per-channel mask chooses which channels follow the strobe, so any subset of outputs can change together.

The serial pins, the load strobe and the clear input are resynchronised into a faster system clock, and the block finds their edges there. An active-low clear input holds every output register at a software-chosen code. Other commands set a per-channel power-down mode, switch the internal reference on, or return the whole block to its power-on state. Code width is a parameter (12, 14 or 16 bits). A build parameter picks whether codes start at zero or at midscale.

Top module: `octdac_ctrl`

## Requirements
- R1: After reset every output code equals the power-on code: zero, or 1 << (RES-1) when POR_MID is set. Every power-down mode is 00 and the reference flag is 0.
- R2: A frame starts when the strobe falls. Data bits are sampled on falling serial clock edges, most significant bit first, and the frame is taken after 32 bits. Bits 27:24 are the command and bits 23:20 the channel, where 1111 means all channels. The code is bits 19:4, left-aligned, so for RES below 16 the low 16-RES bits of that field are ignored.
- R3: Command 0 writes the staging register of the addressed channel(s) and leaves every output unchanged. Command 1 copies staging to output for the addressed channel(s).
- R4: Command 3 writes and then updates the addressed channel(s). Command 2 writes the addressed channel(s) and then updates all eight outputs from their staging registers.
- R5: If the strobe rises before the 32nd bit, the frame is dropped and nothing changes.
- R6: A falling edge of the load strobe while no frame is in progress copies staging to output for every channel whose mask bit is 0.
- R7: If the load strobe is low when the 32nd bit of a frame arrives, every unmasked channel updates after that frame's write has taken effect.
- R8: Command 6 loads the mask from bits 7:0, bit n for channel n. A 1 makes that channel ignore the hardware load strobe; software update commands still reach it.
- R9: While the clear input is low, every output code equals the clear code, which command 5 picks from bits 1:0: 00 zero, 01 midscale, 10 full scale, 11 zero. Clear wins over any update in the same cycle. Staging registers keep accepting writes, and outputs stay at the clear code after release until the next update.
- R10: Command 4 sets the power-down mode (bits 9:8) of every channel whose bit in 7:0 is 1. Other channels keep their modes.
- R11: The reference flag is 0 until command 8 is received; it then takes the value of bit 0.
- R12: Command 7 returns staging, output, power-down, mask, clear selection and reference to their power-on values.
- R13: Command codes 9 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low power-on reset |
| sclk | input | 1 | Serial clock, data sampled on falling edges |
| sync_n | input | 1 | Active-low frame strobe |
| din | input | 1 | Serial data |
| ldac_n | input | 1 | Active-low hardware load strobe |
| clr_n | input | 1 | Active-low clear to the selected clear code |
| dac_code | output | NCH*RES | Output codes, channel n at [n*RES +: RES] |
| pd_mode | output | NCH*2 | Power-down mode, channel n at [2n +: 2], 00 normal |
| ref_en | output | 1 | Internal reference enable |

## Verification
Clear and update can land in the same cycle, because an update command or a synchronous load can finish while the clear input is held low. The bench provokes this by keeping clear low while it sends a write-and-update frame and while it changes the clear selection. It expects the outputs to show the clear code throughout, the staging value to surface only through a later update, and the clear-selection change to show at once. A second overlap comes from the load strobe: it falls in the middle of a frame and stays low. The bench expects no update at that fall and exactly one at the frame's end, after that frame's write.

// File: rtl/octdac_pkg.sv
package octdac_pkg;
  localparam int FRAME_BITS = 32;
  localparam int CMD_LSB    = 24;
  localparam int ADDR_LSB   = 20;
  localparam int DATA_LSB   = 4;
  localparam logic [3:0] ADDR_ALL = 4'hF;

  typedef enum logic [3:0] {
    CMD_STAGE      = 4'd0,
    CMD_COMMIT     = 4'd1,
    CMD_STAGE_ALL  = 4'd2,
    CMD_STAGE_ONE  = 4'd3,
    CMD_POWER      = 4'd4,
    CMD_CLR_SEL    = 4'd5,
    CMD_MASK       = 4'd6,
    CMD_SOFT_RST   = 4'd7,
    CMD_REF        = 4'd8
  } cmd_e;

  // Clear code for a selection, right-aligned in 16 bits.
  function automatic logic [15:0] clear_code(input logic [1:0] sel, input int res);
    logic [31:0] v;
    case (sel)
      2'b01:   v = 32'd1 << (res - 1);
      2'b10:   v = (32'd1 << res) - 32'd1;
      default: v = 32'd0;
    endcase
    return v[15:0];
  endfunction

  function automatic logic [15:0] por_code(input bit mid, input int res);
    return mid ? clear_code(2'b01, res) : 16'd0;
  endfunction

  // Left-aligned data field to a right-aligned code.
  function automatic logic [15:0] field_code(input logic [31:0] w, input int res);
    return w[DATA_LSB +: 16] >> (16 - res);
  endfunction
endpackage

// File: rtl/octdac_sync.sv
module octdac_sync #(
  parameter int W = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= INIT;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/octdac_rx.sv
module octdac_rx
  import octdac_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_s,
  input  logic                  sync_s,
  input  logic                  din_s,
  output logic                  frm_valid,
  output logic [FRAME_BITS-1:0] frm_word,
  output logic                  abort_evt,
  output logic                  busy
);
  localparam int CW = $clog2(FRAME_BITS);

  logic                  sclk_d, sync_d;
  logic [CW-1:0]         cnt;
  logic [FRAME_BITS-1:0] shreg;
  logic                  sclk_fall, sync_fall, sync_rise;

  assign sclk_fall = sclk_d & ~sclk_s;
  assign sync_fall = sync_d & ~sync_s;
  assign sync_rise = ~sync_d & sync_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d    <= 1'b1;
      sync_d    <= 1'b1;
      cnt       <= '0;
      shreg     <= '0;
      frm_word  <= '0;
      frm_valid <= 1'b0;
      abort_evt <= 1'b0;
      busy      <= 1'b0;
    end else begin
      sclk_d    <= sclk_s;
      sync_d    <= sync_s;
      frm_valid <= 1'b0;
      abort_evt <= 1'b0;
      if (sync_fall) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy && sync_rise) begin
        busy      <= 1'b0;
        abort_evt <= 1'b1;
      end else if (busy && sclk_fall) begin
        shreg <= {shreg[FRAME_BITS-2:0], din_s};
        if (cnt == CW'(FRAME_BITS - 1)) begin
          busy      <= 1'b0;
          frm_valid <= 1'b1;
          frm_word  <= {shreg[FRAME_BITS-2:0], din_s};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/octdac_chan.sv
module octdac_chan
  import octdac_pkg::*;
#(
  parameter int RES = 12,
  parameter bit POR_MID = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst,
  input  logic           wr_en,
  input  logic [RES-1:0] wr_data,
  input  logic           upd_en,
  input  logic           clr_force,
  input  logic [RES-1:0] clr_val,
  input  logic           pd_wr,
  input  logic [1:0]     pd_val,
  output logic [RES-1:0] dac_q,
  output logic [1:0]     pd_q
);
  localparam logic [RES-1:0] POR = RES'(por_code(POR_MID, RES));

  logic [RES-1:0] stage_q, stage_nxt;

  // An update in the write cycle sees the newly written value.
  assign stage_nxt = wr_en ? wr_data : stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= POR;
      dac_q   <= POR;
      pd_q    <= 2'b00;
    end else if (soft_rst) begin
      stage_q <= POR;
      dac_q   <= POR;
      pd_q    <= 2'b00;
    end else begin
      stage_q <= stage_nxt;
      if (clr_force)   dac_q <= clr_val;
      else if (upd_en) dac_q <= stage_nxt;
      if (pd_wr) pd_q <= pd_val;
    end
  end
endmodule

// File: rtl/octdac_ctrl.sv
module octdac_ctrl
  import octdac_pkg::*;
#(
  parameter int RES = 12,
  parameter int NCH = 8,
  parameter bit POR_MID = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               sync_n,
  input  logic               din,
  input  logic               ldac_n,
  input  logic               clr_n,
  output logic [NCH*RES-1:0] dac_code,
  output logic [NCH*2-1:0]   pd_mode,
  output logic               ref_en
);
  localparam int NPIN = 5;

  // Resynchronised pins: {clr_n, ldac_n, din, sync_n, sclk}
  logic [NPIN-1:0] pins_s;
  octdac_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .INIT(5'b11011)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({clr_n, ldac_n, din, sync_n, sclk}),
    .q(pins_s)
  );

  logic sclk_s, sync_s, din_s, ldac_s, clr_s;
  assign {clr_s, ldac_s, din_s, sync_s, sclk_s} = pins_s;

  // Frame capture
  logic                  frm_valid, abort_evt, rx_busy;
  logic [FRAME_BITS-1:0] frm_word;
  octdac_rx rx_i (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .sync_s(sync_s), .din_s(din_s),
    .frm_valid(frm_valid), .frm_word(frm_word),
    .abort_evt(abort_evt), .busy(rx_busy)
  );

  // Frame fields
  cmd_e           cmd;
  logic [3:0]     addr;
  logic [RES-1:0] wdata;
  assign cmd   = cmd_e'(frm_word[CMD_LSB +: 4]);
  assign addr  = frm_word[ADDR_LSB +: 4];
  assign wdata = RES'(field_code(frm_word, RES));

  // Control state
  logic [NCH-1:0] ldac_mask;
  logic [1:0]     clr_sel;
  logic           ldac_d;
  logic           soft_rst;

  assign soft_rst = frm_valid && (cmd == CMD_SOFT_RST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldac_mask <= '0;
      clr_sel   <= 2'b00;
      ref_en    <= 1'b0;
      ldac_d    <= 1'b1;
    end else begin
      ldac_d <= ldac_s;
      if (soft_rst) begin
        ldac_mask <= '0;
        clr_sel   <= 2'b00;
        ref_en    <= 1'b0;
      end else if (frm_valid) begin
        if (cmd == CMD_MASK)    ldac_mask <= frm_word[NCH-1:0];
        if (cmd == CMD_CLR_SEL) clr_sel   <= frm_word[1:0];
        if (cmd == CMD_REF)     ref_en    <= frm_word[0];
      end
    end
  end

  // Hardware load events: an edge outside a frame, or a low level at frame end
  logic ldac_fall_idle, ldac_at_end, hw_evt, clr_lvl;
  assign ldac_fall_idle = ldac_d && !ldac_s && !rx_busy;
  assign ldac_at_end    = frm_valid && !ldac_s;
  assign hw_evt         = ldac_fall_idle || ldac_at_end;
  assign clr_lvl        = !clr_s;

  logic [RES-1:0] clr_val;
  assign clr_val = RES'(clear_code(clr_sel, RES));

  logic [NCH-1:0] wr_vec, upd_vec, pd_wr_vec;

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_ch
      logic hit, sw_wr, sw_upd;
      assign hit    = (addr == ADDR_ALL) || (addr == 4'(ch));
      assign sw_wr  = frm_valid && hit &&
                      (cmd == CMD_STAGE || cmd == CMD_STAGE_ALL || cmd == CMD_STAGE_ONE);
      assign sw_upd = frm_valid &&
                      ((hit && (cmd == CMD_COMMIT || cmd == CMD_STAGE_ONE)) ||
                       cmd == CMD_STAGE_ALL);
      assign wr_vec[ch]    = sw_wr;
      assign upd_vec[ch]   = sw_upd || (hw_evt && !ldac_mask[ch]);
      assign pd_wr_vec[ch] = frm_valid && (cmd == CMD_POWER) && frm_word[ch];

      octdac_chan #(.RES(RES), .POR_MID(POR_MID)) chan_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr_en(wr_vec[ch]), .wr_data(wdata),
        .upd_en(upd_vec[ch]),
        .clr_force(clr_lvl), .clr_val(clr_val),
        .pd_wr(pd_wr_vec[ch]), .pd_val(frm_word[9:8]),
        .dac_q(dac_code[ch*RES +: RES]),
        .pd_q(pd_mode[ch*2 +: 2])
      );
    end
  endgenerate
endmodule

// File: rtl/octdac_chk.sv
module octdac_chk
  import octdac_pkg::*;
#(
  parameter int RES = 12,
  parameter int NCH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frm_valid,
  input logic               abort_evt,
  input logic               hw_evt,
  input logic               clr_lvl,
  input logic               soft_rst,
  input logic [1:0]         clr_sel,
  input logic [NCH-1:0]     upd_vec,
  input logic [NCH-1:0]     ldac_mask,
  input logic [NCH*RES-1:0] dac_code,
  input logic [NCH*2-1:0]   pd_mode,
  input logic               ref_en
);
  logic clr_match;
  always_comb begin
    clr_match = 1'b1;
    for (int i = 0; i < NCH; i++)
      if (dac_code[i*RES +: RES] != RES'(clear_code(clr_sel, RES))) clr_match = 1'b0;
  end

  // R2: a completed frame is never followed by another one in the next cycle
  assert_frame_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> !frm_valid);

  // R5: a dropped frame never completes in the same cycle
  assert_abort_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |-> !frm_valid);

  // R6: output codes move only after an update, a clear or a soft reset
  assert_dac_moves_on_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code)) |-> $past((|upd_vec) || clr_lvl || soft_rst));

  // R8: masked channels never take a hardware-only load
  assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_evt && !frm_valid) |-> ((upd_vec & ldac_mask) == '0));

  // R9: a held clear keeps every output at the selected clear code
  assert_clear_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_lvl) && $stable(clr_sel) && !$past(soft_rst)) |-> clr_match);

  // R10: power-down modes change only after a complete frame
  assert_pd_from_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode != $past(pd_mode)) |-> $past(frm_valid));

  // R11: the reference turns on only after a complete frame
  assert_ref_from_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_en) |-> $past(frm_valid));
endmodule

bind octdac_ctrl octdac_chk #(.RES(RES), .NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .frm_valid(frm_valid), .abort_evt(abort_evt), .hw_evt(hw_evt),
  .clr_lvl(clr_lvl), .soft_rst(soft_rst), .clr_sel(clr_sel),
  .upd_vec(upd_vec), .ldac_mask(ldac_mask),
  .dac_code(dac_code), .pd_mode(pd_mode), .ref_en(ref_en)
);

// File: tb/octdac_ctrl_tb.sv
module octdac_ctrl_tb_top;
  localparam int RES = 12;
  localparam int NCH = 8;
  localparam bit POR_MID = 1'b0;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, sync_n = 1'b1, din = 1'b0, ldac_n = 1'b1, clr_n = 1'b1;
  logic [NCH*RES-1:0] dac_code;
  logic [NCH*2-1:0]   pd_mode;
  logic               ref_en;

  always #5 clk = ~clk;

  octdac_ctrl #(.RES(RES), .NCH(NCH), .POR_MID(POR_MID)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .din(din),
    .ldac_n(ldac_n), .clr_n(clr_n),
    .dac_code(dac_code), .pd_mode(pd_mode), .ref_en(ref_en)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // Reference model
  logic [RES-1:0] m_stage [NCH];
  logic [RES-1:0] m_dac   [NCH];
  logic [1:0]     m_pd    [NCH];
  logic [NCH-1:0] m_mask;
  logic [1:0]     m_csel;
  logic           m_ref;
  bit             m_clr;

  function automatic logic [RES-1:0] exp_clear(input logic [1:0] s);
    if (s == 2'd1) return {1'b1, {(RES-1){1'b0}}};
    if (s == 2'd2) return {RES{1'b1}};
    return '0;
  endfunction

  function automatic logic [RES-1:0] exp_por();
    return POR_MID ? {1'b1, {(RES-1){1'b0}}} : '0;
  endfunction

  function automatic logic [31:0] mk(input int c, input int a, input logic [15:0] d16);
    return {4'h0, 4'(c), 4'(a), d16, 4'h0};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin
      m_stage[i] = exp_por(); m_dac[i] = exp_por(); m_pd[i] = 2'b00;
    end
    m_mask = '0; m_csel = 2'b00; m_ref = 1'b0;
  endtask

  task automatic model_commit(input int i);
    m_dac[i] = m_stage[i];
  endtask

  task automatic model_frame(input logic [31:0] w, input bit ldac_low);
    int c, a;
    logic [RES-1:0] d;
    c = int'(w[27:24]); a = int'(w[23:20]);
    d = w[19:4] >> (16 - RES);
    if (c == 7) begin
      model_reset();
    end else begin
      for (int i = 0; i < NCH; i++) begin
        bit hit;
        hit = (a == 15) || (a == i);
        if (hit && (c == 0 || c == 2 || c == 3)) m_stage[i] = d;
        if ((hit && (c == 1 || c == 3)) || c == 2) model_commit(i);
        if (ldac_low && !m_mask[i]) model_commit(i);
        if (c == 4 && w[i]) m_pd[i] = w[9:8];
      end
      if (c == 5) m_csel = w[1:0];
      if (c == 6) m_mask = w[7:0];
      if (c == 8) m_ref = w[0];
    end
    if (m_clr) for (int i = 0; i < NCH; i++) m_dac[i] = exp_clear(m_csel);
  endtask

  task automatic check(input string tag);
    logic [NCH*RES-1:0] ed;
    logic [NCH*2-1:0]   ep;
    for (int i = 0; i < NCH; i++) begin
      ed[i*RES +: RES] = m_dac[i];
      ep[i*2 +: 2] = m_pd[i];
    end
    total += 3;
    if (dac_code !== ed) begin
      bad++; $display("FAIL %s dac_code actual=%h expected=%h", tag, dac_code, ed);
    end
    if (pd_mode !== ep) begin
      bad++; $display("FAIL %s pd_mode actual=%h expected=%h", tag, pd_mode, ep);
    end
    if (ref_en !== m_ref) begin
      bad++; $display("FAIL %s ref_en actual=%b expected=%b", tag, ref_en, m_ref);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends nbits of w MSB first; optionally pulls the load strobe low mid-frame.
  task automatic send(input logic [31:0] w, input int nbits, input bit ldac_mid);
    sync_n = 1'b0; ticks(HALF);
    for (int b = 31; b > 31 - nbits; b--) begin
      din = w[b]; ticks(HALF);
      sclk = 1'b0; ticks(HALF);
      sclk = 1'b1;
      if (ldac_mid && b == 27) ldac_n = 1'b0;
    end
    ticks(2); sync_n = 1'b1; ticks(8);
    if (ldac_mid) begin ldac_n = 1'b1; ticks(4); end
  endtask

  task automatic frame(input logic [31:0] w, input bit ldac_mid, input string tag);
    send(w, 32, ldac_mid);
    model_frame(w, ldac_mid);
    check(tag);
  endtask

  task automatic ldac_pulse();
    ldac_n = 1'b0; ticks(4); ldac_n = 1'b1; ticks(6);
    for (int i = 0; i < NCH; i++) if (!m_mask[i]) model_commit(i);
    if (m_clr) for (int i = 0; i < NCH; i++) m_dac[i] = exp_clear(m_csel);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset(); m_clr = 0;
    ticks(4); rst_n = 1'b1; ticks(6);
    check("R1 reset state");

    // R3: staging write is invisible until committed
    frame(mk(0, 2, 16'hABC0), 0, "R3 stage only");
    frame(mk(1, 2, 16'h0000), 0, "R3 commit ch2");

    // R4: write-and-update variants; broadcast address
    frame(mk(3, 5, 16'h1230), 0, "R4 stage+commit one");
    frame(mk(0, 15, 16'h5550), 0, "R3 stage broadcast");
    frame(mk(2, 0, 16'h7770), 0, "R4 stage then commit all");

    // R2: low field bits below RES are dropped
    frame(mk(3, 7, 16'hFFFF), 0, "R2 low bits ignored");

    // R5: truncated frame
    send(mk(3, 1, 16'h9990), 20, 0);
    check("R5 dropped frame");

    // R8 + R6: mask ch0..3, stage all, hardware pulse
    frame(mk(6, 0, 16'h0000) | 32'h0F, 0, "R8 mask load");
    frame(mk(0, 15, 16'h4440), 0, "R3 stage broadcast");
    ldac_pulse();
    check("R6 R8 async load masked");
    frame(mk(1, 1, 16'h0000), 0, "R8 software commit ignores mask");

    // R7: strobe low across a frame end
    frame(mk(0, 6, 16'hD0D0), 1, "R7 synchronous load");

    // R9: clear beats updates; selection change while held
    frame(mk(5, 0, 16'h0000) | 32'h2, 0, "R9 clear select full");
    clr_n = 1'b0; ticks(6); m_clr = 1;
    for (int i = 0; i < NCH; i++) m_dac[i] = exp_clear(m_csel);
    check("R9 clear full scale");
    frame(mk(3, 3, 16'h3210), 0, "R9 update during clear");
    frame(mk(5, 0, 16'h0000) | 32'h1, 0, "R9 clear select mid");
    clr_n = 1'b1; ticks(6); m_clr = 0;
    check("R9 release keeps clear code");
    frame(mk(1, 3, 16'h0000), 0, "R9 staging survived clear");

    // R10, R11, R13, R12
    frame(mk(4, 0, 16'h0000) | 32'h2A5, 0, "R10 power-down mode");
    frame(mk(8, 0, 16'h0000) | 32'h1, 0, "R11 reference on");
    frame(mk(12, 15, 16'hFFF0), 0, "R13 unknown command");
    frame(mk(7, 0, 16'h0000), 0, "R12 soft reset");

    // Constrained random traffic
    begin
      int unsigned seed;
      seed = $urandom(32'h5EED);
      for (int n = 0; n < 60; n++) begin
        logic [31:0] w;
        int c, a;
        c = int'($urandom_range(0, 9));
        if (c == 7 && ($urandom_range(0, 3) != 0)) c = 3;
        a = ($urandom_range(0, 4) == 0) ? 15 : int'($urandom_range(0, 7));
        w = {4'h0, 4'(c), 4'(a), 16'($urandom), 4'($urandom)};
        frame(w, ($urandom_range(0, 5) == 0), "R2 random frame");
        if ($urandom_range(0, 7) == 0) begin
          ldac_pulse();
          check("R6 random pulse");
        end
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule